// File: doc/BRIEF.md
# Indirect Table Access Port

This block lets a register bus reach a family of internal lookup tables through two registers: an address register and a data register. The address register names one table and one entry inside it, and carries an autoincrement flag. Each access to the data register reaches the entry it points at. Before use, the entry index is ANDed with the selected table's size mask. When autoincrement is on, the index then steps forward and wraps within that table. Software can therefore walk a whole table with one address write followed by a run of data accesses.

Sixteen table identifiers exist. Six of them have storage. Eight are legal but have no storage, so they read as zero and drop writes. The remaining two are unknown and are answered with an error. After every completed data write, a one-cycle side-effect strobe carries the table identifier and the masked index, so that neighbouring logic can react. Writes to the interrupt-vector table are filtered before they are stored.

A small state machine sequences each request. From **IDLE**, an accepted request moves to **FETCH** when it is a data read of a table with storage, because storage has one cycle of read latency. Every other accepted request moves straight to **REPLY**. **FETCH** always moves to **REPLY**. **REPLY** asserts the acknowledge for one cycle and always returns to **IDLE**.

Top module: `itab_port`

## Requirements
- R1: After reset, `bus_ack`, `bus_err` and `fx_valid` are low, and a read of the address register returns zero.
- R2: The address register keeps only the autoincrement flag (bit 31), the table select (bits 19:16) and the raw entry index (bits 8:0). A read returns exactly those bits and zero elsewhere.
- R3: A data access uses the index ANDed with the table mask. Entry counts by table select are: 0→8, 1→8, 2→512, 3→16, 4→256, 5→4, 6→32, 7→32, 8→64, 9→8, 10→256, 11→256, 12→64, 13→64.
- R4: With autoincrement set, a data access to a known table leaves ((masked index + 1) AND mask) in the index field, so the index wraps to 0 after the last entry. With autoincrement clear, the address register is left unchanged.
- R5: Tables 0 to 5 have storage, and a data read returns the value last written to that entry. A read of one of these tables is acknowledged two cycles after the request is accepted; every other access is acknowledged one cycle after.
- R6: Tables 6 to 13 have no storage. Reads of them return zero and writes to them are discarded.
- R7: Autoincrement advances the index for tables without storage in the same way as for tables with storage.
- R8: Table selects 14 and 15 are unknown. A data access to them returns zero with `bus_err` high alongside `bus_ack`, changes no state, does not move the index and raises no strobe.
- R9: A write to table 1 stores only three fields: priority from write bits 7:0 into bits 7:0, server bits 15:8 shifted right by two into bits 15:8, and node ID from bits 19:16 into bits 19:16. All other stored bits are zero.
- R10: Every completed data write to a known table raises `fx_valid` for exactly one cycle, in the cycle of `bus_ack`. During that cycle `fx_table` carries the table select and `fx_index` carries the masked index.
- R11: `bus_ack` is high for exactly one cycle per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Request strobe, sampled in IDLE |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_dsel | input | 1 | 1 = data register, 0 = address register |
| bus_wdata | input | DATA_W | Write data |
| bus_ack | output | 1 | Request completed (one cycle) |
| bus_err | output | 1 | Unknown table select, valid with bus_ack |
| bus_rdata | output | DATA_W | Read data, valid with bus_ack |
| fx_valid | output | 1 | Side-effect strobe for a data write |
| fx_table | output | 4 | Table select of the strobed write |
| fx_index | output | 9 | Masked entry index of the strobed write |

## Verification
The assertions assume that the requester raises `bus_req` only while the port is idle, that is, only after the previous acknowledge. They also assume that `bus_req` is low during reset. The stimulus issues one request at a time and waits for `bus_ack` before starting the next, so the state machine never sees a request outside IDLE. The sweep touches every table select, walks every entry of every known table across the wrap point, and starts each walk from an index whose bits lie above the mask. Expected read values, indices and latencies are derived arithmetically from the entry counts and field positions stated in the requirements.

// File: rtl/itab_pkg.sv
package itab_pkg;

    localparam int TSEL_W  = 4;
    localparam int NUM_TBL = 1 << TSEL_W;
    localparam int IDX_W   = 9;

    // address register field positions
    localparam int AINC_POS = 31;
    localparam int TSEL_POS = 16;
    localparam int IDX_POS  = 0;

    // interrupt-vector entry field positions
    localparam int VEC_PRIO_LSB = 0;
    localparam int VEC_SRV_LSB  = 8;
    localparam int VEC_NODE_LSB = 16;
    localparam int VEC_FLD_W    = 8;
    localparam int VEC_NODE_W   = 4;
    localparam int VEC_LINK_W   = 2;

    typedef enum logic [TSEL_W-1:0] {
        TB_CHAIN = 4'd0,
        TB_IRQV  = 4'd1,
        TB_XLAT  = 4'd2,
        TB_WIN   = 4'd3,
        TB_SEG   = 4'd4,
        TB_EVT   = 4'd5,
        TB_CAMA  = 4'd6,
        TB_CAMB  = 4'd7,
        TB_RCAM  = 4'd8,
        TB_MAPR  = 4'd9,
        TB_STA   = 4'd10,
        TB_STB   = 4'd11,
        TB_TCAM  = 4'd12,
        TB_TDR   = 4'd13
    } tbl_id_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_FETCH = 2'd1,
        S_REPLY = 2'd2
    } port_state_e;

    // log2 of the entry count; 0 for unknown selects
    function automatic int tbl_log2(input logic [TSEL_W-1:0] id);
        case (id)
            TB_CHAIN: return 3;
            TB_IRQV:  return 3;
            TB_XLAT:  return 9;
            TB_WIN:   return 4;
            TB_SEG:   return 8;
            TB_EVT:   return 2;
            TB_CAMA:  return 5;
            TB_CAMB:  return 5;
            TB_RCAM:  return 6;
            TB_MAPR:  return 3;
            TB_STA:   return 8;
            TB_STB:   return 8;
            TB_TCAM:  return 6;
            TB_TDR:   return 6;
            default:  return 0;
        endcase
    endfunction

    function automatic logic tbl_valid(input logic [TSEL_W-1:0] id);
        return id <= TB_TDR;
    endfunction

    function automatic logic tbl_stored(input logic [TSEL_W-1:0] id);
        return id <= TB_EVT;
    endfunction

    function automatic logic [IDX_W-1:0] tbl_mask(input logic [TSEL_W-1:0] id);
        return IDX_W'((1 << tbl_log2(id)) - 1);
    endfunction

endpackage

// File: rtl/itab_decode.sv
module itab_decode
    import itab_pkg::*;
(
    input  logic [TSEL_W-1:0] tsel,
    output logic              sel_valid,
    output logic              sel_stored,
    output logic [IDX_W-1:0]  sel_mask
);

    always_comb begin
        sel_valid  = tbl_valid(tsel);
        sel_stored = tbl_valid(tsel) && tbl_stored(tsel);
        sel_mask   = tbl_valid(tsel) ? tbl_mask(tsel) : '0;
    end

endmodule

// File: rtl/itab_store.sv
module itab_store #(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[addr] <= wdata;
        end
        if (rd_en) begin
            rdata <= mem[addr];
        end
    end

endmodule

// File: rtl/itab_addr_reg.sv
module itab_addr_reg
    import itab_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_ainc,
    input  logic [TSEL_W-1:0] wr_tsel,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              adv_en,
    input  logic [IDX_W-1:0]  adv_mask,
    output logic              ainc,
    output logic [TSEL_W-1:0] tsel,
    output logic [IDX_W-1:0]  idx,
    output logic [DATA_W-1:0] rd_val
);

    logic [IDX_W-1:0] idx_step;

    always_comb begin
        idx_step = ((idx & adv_mask) + IDX_W'(1)) & adv_mask;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ainc <= 1'b0;
            tsel <= '0;
            idx  <= '0;
        end else if (wr_en) begin
            ainc <= wr_ainc;
            tsel <= wr_tsel;
            idx  <= wr_idx;
        end else if (adv_en && ainc) begin
            idx <= idx_step;
        end
    end

    always_comb begin
        rd_val                     = '0;
        rd_val[AINC_POS]           = ainc;
        rd_val[TSEL_POS +: TSEL_W] = tsel;
        rd_val[IDX_POS +: IDX_W]   = idx;
    end

    // R4
    idx_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(adv_en) && $past(ainc)) |-> ((idx & ~$past(adv_mask)) == '0));

    // R4
    idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !(adv_en && ainc)) |=> $stable(idx) && $stable(tsel));

endmodule

// File: rtl/itab_port.sv
module itab_port
    import itab_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic              bus_dsel,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              bus_ack,
    output logic              bus_err,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              fx_valid,
    output logic [TSEL_W-1:0] fx_table,
    output logic [IDX_W-1:0]  fx_index
);

    port_state_e state, state_nx;

    logic              cur_ainc;
    logic [TSEL_W-1:0] cur_tsel;
    logic [IDX_W-1:0]  cur_idx;
    logic [DATA_W-1:0] addr_rd;
    logic              sel_valid, sel_stored;
    logic [IDX_W-1:0]  sel_mask, midx;

    logic              accept, data_acc, addr_wr, adv_en, fetch_go;
    logic [DATA_W-1:0] wdata_eff;
    logic [DATA_W-1:0] rd_q [NUM_TBL];
    logic [TSEL_W-1:0] rd_tbl;
    logic              err_q;

    itab_addr_reg #(.DATA_W(DATA_W)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (addr_wr),
        .wr_ainc  (bus_wdata[AINC_POS]),
        .wr_tsel  (bus_wdata[TSEL_POS +: TSEL_W]),
        .wr_idx   (bus_wdata[IDX_POS +: IDX_W]),
        .adv_en   (adv_en),
        .adv_mask (sel_mask),
        .ainc     (cur_ainc),
        .tsel     (cur_tsel),
        .idx      (cur_idx),
        .rd_val   (addr_rd)
    );

    itab_decode u_dec (
        .tsel       (cur_tsel),
        .sel_valid  (sel_valid),
        .sel_stored (sel_stored),
        .sel_mask   (sel_mask)
    );

    always_comb begin
        midx     = cur_idx & sel_mask;
        accept   = (state == S_IDLE) && bus_req;
        data_acc = accept && bus_dsel;
        addr_wr  = accept && !bus_dsel && bus_we;
        adv_en   = data_acc && sel_valid;
        fetch_go = data_acc && !bus_we && sel_stored;
    end

    // write filter for the interrupt-vector table
    always_comb begin
        if (cur_tsel == TB_IRQV) begin
            wdata_eff = '0;
            wdata_eff[VEC_PRIO_LSB +: VEC_FLD_W] = bus_wdata[VEC_PRIO_LSB +: VEC_FLD_W];
            wdata_eff[VEC_SRV_LSB +: VEC_FLD_W] =
                {{VEC_LINK_W{1'b0}}, bus_wdata[VEC_SRV_LSB + VEC_LINK_W +: VEC_FLD_W - VEC_LINK_W]};
            wdata_eff[VEC_NODE_LSB +: VEC_NODE_W] = bus_wdata[VEC_NODE_LSB +: VEC_NODE_W];
        end else begin
            wdata_eff = bus_wdata;
        end
    end

    for (genvar t = 0; t < NUM_TBL; t++) begin : g_tbl
        if (tbl_valid(TSEL_W'(t)) && tbl_stored(TSEL_W'(t))) begin : g_mem
            localparam int LG = tbl_log2(TSEL_W'(t));
            logic hit;
            always_comb hit = data_acc && (cur_tsel == TSEL_W'(t));
            itab_store #(.ADDR_W(LG), .DATA_W(DATA_W)) u_store (
                .clk   (clk),
                .wr_en (hit && bus_we),
                .rd_en (hit && !bus_we),
                .addr  (midx[LG-1:0]),
                .wdata (wdata_eff),
                .rdata (rd_q[t])
            );
        end else begin : g_none
            assign rd_q[t] = '0;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: begin
                if (accept) begin
                    state_nx = fetch_go ? S_FETCH : S_REPLY;
                end
            end
            S_FETCH: state_nx = S_REPLY;
            S_REPLY: state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // response datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
            err_q     <= 1'b0;
            fx_valid  <= 1'b0;
            fx_table  <= '0;
            fx_index  <= '0;
            rd_tbl    <= '0;
        end else if (accept) begin
            fx_valid <= 1'b0;
            err_q    <= 1'b0;
            rd_tbl   <= cur_tsel;
            if (!bus_dsel) begin
                bus_rdata <= bus_we ? '0 : addr_rd;
            end else if (!sel_valid) begin
                bus_rdata <= '0;
                err_q     <= 1'b1;
            end else if (bus_we) begin
                bus_rdata <= '0;
                fx_valid  <= 1'b1;
                fx_table  <= cur_tsel;
                fx_index  <= midx;
            end else begin
                bus_rdata <= '0;
            end
        end else if (state == S_FETCH) begin
            bus_rdata <= rd_q[rd_tbl];
            fx_valid  <= 1'b0;
        end else begin
            fx_valid <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        bus_ack = (state == S_REPLY);
        bus_err = (state == S_REPLY) && err_q;
    end

    // R10
    fx_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fx_valid |-> (bus_ack && !bus_err));

    // R3
    fx_index_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fx_valid |-> ((fx_index & ~tbl_mask(fx_table)) == '0));

    // R11
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |=> !bus_ack);

    // R5
    fetch_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_go |=> (!bus_ack ##1 bus_ack));

    // R8
    err_no_fx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> (!fx_valid && bus_rdata == '0));

endmodule

// File: tb/itab_port_tb.sv
`timescale 1ns/1ps
module itab_port_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic        bus_dsel = 1'b0;
    logic [63:0] bus_wdata = '0;
    logic        bus_ack, bus_err, fx_valid;
    logic [63:0] bus_rdata;
    logic [3:0]  fx_table;
    logic [8:0]  fx_index;

    int total = 0;
    int fails = 0;
    int cyc   = 0;

    always #2.5 clk = ~clk;

    itab_port #(.DATA_W(64)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_dsel(bus_dsel), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
        .bus_err(bus_err), .bus_rdata(bus_rdata), .fx_valid(fx_valid),
        .fx_table(fx_table), .fx_index(fx_index)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            total = total + 1;
            fails = fails + 1;
            $display("FAIL watchdog: act=%0d exp<=150000 cycles", cyc);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total = total + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // entry counts per R3
    function automatic int exp_log(input int t);
        case (t)
            0: return 3;  1: return 3;  2: return 9;  3: return 4;
            4: return 8;  5: return 2;  6: return 5;  7: return 5;
            8: return 6;  9: return 3;  10: return 8; 11: return 8;
            12: return 6; 13: return 6;
            default: return 0;
        endcase
    endfunction

    function automatic logic [63:0] pat(input int t, input int i);
        return {8'(t), 8'hC3, 16'(i), 32'hDEAD0000 | 32'(i * 37 + t)};
    endfunction

    // stored image per R9 for table 1, raw otherwise
    function automatic logic [63:0] stored_val(input int t, input logic [63:0] w);
        logic [63:0] r;
        if (t != 1) return w;
        r = '0;
        r[7:0]   = w[7:0];
        r[15:8]  = w[15:8] >> 2;
        r[19:16] = w[19:16];
        return r;
    endfunction

    task automatic access(input logic we, input logic dsel, input logic [63:0] wd,
                          output logic [63:0] rd, output logic e, output int lat,
                          output logic fv, output logic [3:0] ft, output logic [8:0] fi);
        @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_dsel = dsel; bus_wdata = wd;
        @(negedge clk);
        bus_req = 1'b0;
        lat = 1;
        while (!bus_ack && lat < 8) begin
            @(negedge clk);
            lat++;
        end
        rd = bus_rdata; e = bus_err; fv = fx_valid; ft = fx_table; fi = fx_index;
    endtask

    initial begin
        logic [63:0] rd, wd, ex;
        logic        e, fv;
        logic [3:0]  ft;
        logic [8:0]  fi;
        int          lat;

        repeat (4) @(negedge clk);
        // R1 reset state
        chk(bus_ack == 1'b0 && bus_err == 1'b0 && fx_valid == 1'b0, "R1 outputs idle",
            {61'd0, bus_ack, bus_err, fx_valid}, 64'd0);
        rst_n = 1'b1;
        access(1'b0, 1'b0, '0, rd, e, lat, fv, ft, fi);
        chk(rd == 64'd0, "R1 address reg after reset", rd, 64'd0);

        // R2 field retention
        access(1'b1, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, rd, e, lat, fv, ft, fi);
        access(1'b0, 1'b0, '0, rd, e, lat, fv, ft, fi);
        chk(rd == 64'h0000_0000_800F_01FF, "R2 address fields only", rd, 64'h800F01FF);
        @(negedge clk);
        chk(bus_ack == 1'b0, "R11 ack single cycle", {63'd0, bus_ack}, 64'd0);

        for (int t = 0; t < 16; t++) begin
            int          lg, n;
            logic        vld, sto;
            logic [8:0]  msk, st;
            lg  = exp_log(t);
            vld = (t < 14);
            sto = (t < 6);
            msk = 9'((1 << lg) - 1);
            n   = vld ? (1 << lg) : 4;
            st  = 9'h1FF & ~msk;

            wd = 64'h8000_0000 | (64'(t) << 16) | 64'(st);
            access(1'b1, 1'b0, wd, rd, e, lat, fv, ft, fi);
            chk(lat == 1, "R5 address write latency", 64'(lat), 64'd1);
            access(1'b0, 1'b0, '0, rd, e, lat, fv, ft, fi);
            chk(rd == wd, "R2 address readback", rd, wd);

            // write walk
            for (int i = 0; i < n; i++) begin
                access(1'b1, 1'b1, pat(t, i), rd, e, lat, fv, ft, fi);
                chk(e == !vld, vld ? "R6 write no error" : "R8 write error", {63'd0, e}, {63'd0, !vld});
                if (vld) begin
                    chk(fv == 1'b1 && ft == 4'(t) && fi == 9'(i), "R10 strobe table and index",
                        {51'd0, fv, ft, fi}, {51'd0, 1'b1, 4'(t), 9'(i)});
                    if (i == 0) begin
                        @(negedge clk);
                        chk(fx_valid == 1'b0, "R10 strobe one cycle", {63'd0, fx_valid}, 64'd0);
                    end
                end else begin
                    chk(fv == 1'b0, "R8 no strobe on unknown table", {63'd0, fv}, 64'd0);
                end
            end

            access(1'b0, 1'b0, '0, rd, e, lat, fv, ft, fi);
            ex = 64'h8000_0000 | (64'(t) << 16) | (vld ? 64'd0 : 64'(st));
            chk(rd == ex, vld ? (sto ? "R4 wrap after walk" : "R7 wrap without storage")
                              : "R8 index not moved", rd, ex);

            // read walk
            access(1'b1, 1'b0, wd, rd, e, lat, fv, ft, fi);
            for (int i = 0; i < n; i++) begin
                access(1'b0, 1'b1, '0, rd, e, lat, fv, ft, fi);
                ex = (vld && sto) ? stored_val(t, pat(t, i)) : 64'd0;
                chk(rd == ex, (t == 1) ? "R9 vector filter" : (sto ? "R5 readback" :
                    (vld ? "R6 zero read" : "R8 zero read")), rd, ex);
                chk(e == !vld, "R8 read error flag", {63'd0, e}, {63'd0, !vld});
                chk(lat == ((vld && sto) ? 2 : 1), "R5 read latency", 64'(lat),
                    (vld && sto) ? 64'd2 : 64'd1);
            end

            // index masking without autoincrement
            if (vld) begin
                wd = (64'(t) << 16) | 64'h1FF;
                access(1'b1, 1'b0, wd, rd, e, lat, fv, ft, fi);
                access(1'b1, 1'b1, ~pat(t, 0), rd, e, lat, fv, ft, fi);
                chk(fi == msk, "R3 masked strobe index", 64'(fi), 64'(msk));
                access(1'b0, 1'b1, '0, rd, e, lat, fv, ft, fi);
                ex = sto ? stored_val(t, ~pat(t, 0)) : 64'd0;
                chk(rd == ex, sto ? "R3 masked entry readback" : "R6 discarded write", rd, ex);
                access(1'b0, 1'b0, '0, rd, e, lat, fv, ft, fi);
                chk(rd == wd, "R4 no autoincrement keeps register", rd, wd);
            end
        end

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule